// File: doc/BRIEF.md
# Dual Bitstream Output Multiplexer

This block sits between two 1-bit oversampling modulators and the two data pins of a sensing front end. One modulator carries the current channel and the other the voltage channel. The block decides what appears on the primary data pin `dat` and on its companion `dat_n`. The inputs that steer it are a 6-bit test selector, a voltage-channel power-down flag and a multiplex enable. In multiplexed mode both streams share one pin: the clock phase picks which stream is shown.

The same selector can replace either stream with one of four internal diagnostic signals of that channel. These are the low-frequency chopper, the high-frequency chopper, the self-test pattern and the pseudo-random dither. When the configuration is not software controlled, a 2-bit strap code decides the routing and all software settings are ignored. Every stream and diagnostic bit is registered on the rising clock edge before routing, so each interleaved half-period holds a stable value.

Top module: `obmux_top`

## Requirements
- R1: With software control, selector bits [5:4] = 00, voltage powered and multiplex enabled, `dat` shows the captured voltage bit while `clk` is high and the captured current bit while `clk` is low, and `dat_n` is always the inverse of `dat`.
- R2: With software control, selector bits [5:4] = 00, voltage powered and multiplex disabled, `dat` equals the captured voltage bit and `dat_n` equals the captured current bit.
- R3: With software control, selector bits [5:4] = 00 and `volt_pd` = 1, `dat` equals the captured current bit and `dat_n` its inverse, for either value of `mux_en`.
- R4: With software control and selector bits [5:4] = 01, `dat_n` shows `diag_c[test_sel[1:0]]` as captured (index 0 low-frequency chopper, 1 high-frequency chopper, 2 self-test, 3 pseudo-random), while `dat` keeps the routing R1 to R3 give it.
- R5: With software control and selector bits [5:4] = 10, `dat` shows `diag_v[test_sel[3:2]]` as captured (same index order as R4), while `dat_n` keeps the routing R1 to R3 give it.
- R6: With software control and selector bits [5:4] = 11, `dat` shows `diag_v[test_sel[3:2]]` and `dat_n` shows `diag_c[test_sel[1:0]]`.
- R7: With `soft_mode` = 0 and strap code 3 (tied high), `dat` equals the captured voltage bit and `dat_n` the captured current bit.
- R8: With `soft_mode` = 0 and strap code 1 or 2 (clock or inverted clock), the voltage channel counts as powered down: `dat` equals the captured current bit and `dat_n` its inverse.
- R9: With `soft_mode` = 0 and strap code 0 (tied low), the output is multiplexed as in R1.
- R10: With `soft_mode` = 0, the values of `test_sel`, `volt_pd` and `mux_en` have no effect on `dat` or `dat_n`.
- R11: Stream and diagnostic inputs are captured on the rising edge of `clk`. A change after an edge reaches the outputs only after the next rising edge.
- R12: While `rst_n` is low all captured bits are 0, so under the R2 configuration `dat` = 0 and `dat_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; its level also sets the interleave phase |
| rst_n | input | 1 | Asynchronous active-low reset of the capture stage |
| soft_mode | input | 1 | 1: software configuration used; 0: strap code used |
| strap | input | 2 | Strap code for the output pin: 0 low, 1 clock, 2 inverted clock, 3 high |
| test_sel | input | 6 | [5:4] route class, [3:2] voltage diagnostic index, [1:0] current diagnostic index |
| volt_pd | input | 1 | Voltage modulator powered down (software control) |
| mux_en | input | 1 | Interleave both streams on `dat` (software control) |
| bs_cur | input | 1 | Current-channel modulator bitstream |
| bs_volt | input | 1 | Voltage-channel modulator bitstream |
| diag_c | input | 4 | Current-channel diagnostic signals, indexed as in R4 |
| diag_v | input | 4 | Voltage-channel diagnostic signals, indexed as in R4 |
| dat | output | 1 | Primary data output |
| dat_n | output | 1 | Secondary data output |

## Verification
On every cycle the assertions check the complement relation in the multiplexed and powered-down routings. They also check that the plain, hard-tied-high and single-diagnostic routings present the bit captured one edge earlier. The high-phase content of the interleave is checked at each falling edge. Only the bench scenarios show all four diagnostic indices on both channels, the low half of the interleave, the combined diagnostic class, and that the software settings are ignored under strap control. The bench compares both clock phases of every cycle against its model.

// File: rtl/obmux_pkg.sv
package obmux_pkg;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'd0,
        STRAP_CLK  = 2'd1,
        STRAP_NCLK = 2'd2,
        STRAP_HIGH = 2'd3
    } strap_e;

    typedef enum logic [1:0] {
        RT_NORMAL    = 2'd0,
        RT_DIAG_CUR  = 2'd1,
        RT_DIAG_VOLT = 2'd2,
        RT_DIAG_BOTH = 2'd3
    } route_e;

    typedef struct packed {
        route_e route;
        logic   vpd;
        logic   mux;
    } route_cfg_t;

endpackage

// File: rtl/obmux_cfg.sv
module obmux_cfg
    import obmux_pkg::*;
#(
    parameter int unsigned PICK_W = 2,
    localparam int unsigned SEL_W = 2 + 2 * PICK_W
) (
    input  logic              soft_mode,
    input  logic [1:0]        strap,
    input  logic [SEL_W-1:0]  test_sel,
    input  logic              volt_pd,
    input  logic              mux_en,
    output route_cfg_t        cfg,
    output logic [PICK_W-1:0] pick_c,
    output logic [PICK_W-1:0] pick_v
);

    always_comb begin
        cfg    = '{route: RT_NORMAL, vpd: 1'b0, mux: 1'b0};
        pick_c = '0;
        pick_v = '0;
        if (soft_mode) begin
            cfg.route = route_e'(test_sel[SEL_W-1 -: 2]);
            cfg.vpd   = volt_pd;
            cfg.mux   = mux_en;
            pick_c    = test_sel[PICK_W-1:0];
            pick_v    = test_sel[2*PICK_W-1:PICK_W];
        end else begin
            unique case (strap_e'(strap))
                STRAP_LOW:  cfg.mux = 1'b1;
                STRAP_CLK,
                STRAP_NCLK: cfg.vpd = 1'b1;
                default:    cfg.vpd = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/obmux_capture.sv
module obmux_capture #(
    parameter int unsigned DIAG_N = 4,
    localparam int unsigned W = 2 + 2 * DIAG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bs_cur,
    input  logic              bs_volt,
    input  logic [DIAG_N-1:0] diag_c,
    input  logic [DIAG_N-1:0] diag_v,
    output logic              cur_q,
    output logic              volt_q,
    output logic [DIAG_N-1:0] dc_q,
    output logic [DIAG_N-1:0] dv_q
);

    typedef struct packed {
        logic [DIAG_N-1:0] dv;
        logic [DIAG_N-1:0] dc;
        logic              volt;
        logic              cur;
    } tap_t;

    tap_t tap_d, tap_q;

    always_comb begin
        tap_d.cur  = bs_cur;
        tap_d.volt = bs_volt;
        tap_d.dc   = diag_c;
        tap_d.dv   = diag_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= tap_t'({W{1'b0}});
        else        tap_q <= tap_d;
    end

    assign cur_q  = tap_q.cur;
    assign volt_q = tap_q.volt;
    assign dc_q   = tap_q.dc;
    assign dv_q   = tap_q.dv;

endmodule

// File: rtl/obmux_pick.sv
module obmux_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = 2
) (
    input  logic [N-1:0]  src,
    input  logic [SW-1:0] sel,
    output logic          bit_o
);

    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_hit
            assign hit[i] = src[i] & (sel == SW'(i));
        end
    endgenerate

    assign bit_o = |hit;

endmodule

// File: rtl/obmux_route.sv
module obmux_route
    import obmux_pkg::*;
(
    input  route_cfg_t cfg,
    input  logic       phase,
    input  logic       cur,
    input  logic       volt,
    input  logic       diag_cur,
    input  logic       diag_volt,
    output logic       dat,
    output logic       dat_n
);

    logic norm_p, norm_s;

    always_comb begin
        if (cfg.vpd) begin
            norm_p = cur;
            norm_s = ~cur;
        end else if (cfg.mux) begin
            norm_p = phase ? volt : cur;
            norm_s = ~norm_p;
        end else begin
            norm_p = volt;
            norm_s = cur;
        end
    end

    always_comb begin
        unique case (cfg.route)
            RT_DIAG_CUR:  begin dat = norm_p;    dat_n = diag_cur; end
            RT_DIAG_VOLT: begin dat = diag_volt; dat_n = norm_s;   end
            RT_DIAG_BOTH: begin dat = diag_volt; dat_n = diag_cur; end
            default:      begin dat = norm_p;    dat_n = norm_s;   end
        endcase
    end

endmodule

// File: rtl/obmux_top.sv
module obmux_top
    import obmux_pkg::*;
#(
    parameter int unsigned DIAG_N = 4,
    localparam int unsigned PICK_W = (DIAG_N > 1) ? $clog2(DIAG_N) : 1,
    localparam int unsigned SEL_W  = 2 + 2 * PICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_mode,
    input  logic [1:0]        strap,
    input  logic [SEL_W-1:0]  test_sel,
    input  logic              volt_pd,
    input  logic              mux_en,
    input  logic              bs_cur,
    input  logic              bs_volt,
    input  logic [DIAG_N-1:0] diag_c,
    input  logic [DIAG_N-1:0] diag_v,
    output logic              dat,
    output logic              dat_n
);

    route_cfg_t        cfg;
    logic [PICK_W-1:0] pick_c, pick_v;
    logic              cur_q, volt_q;
    logic [DIAG_N-1:0] dc_q, dv_q;
    logic              dsel_c, dsel_v;

    obmux_cfg #(.PICK_W(PICK_W)) u_cfg (
        .soft_mode (soft_mode),
        .strap     (strap),
        .test_sel  (test_sel),
        .volt_pd   (volt_pd),
        .mux_en    (mux_en),
        .cfg       (cfg),
        .pick_c    (pick_c),
        .pick_v    (pick_v)
    );

    obmux_capture #(.DIAG_N(DIAG_N)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bs_cur  (bs_cur),
        .bs_volt (bs_volt),
        .diag_c  (diag_c),
        .diag_v  (diag_v),
        .cur_q   (cur_q),
        .volt_q  (volt_q),
        .dc_q    (dc_q),
        .dv_q    (dv_q)
    );

    obmux_pick #(.N(DIAG_N), .SW(PICK_W)) u_pick_c (
        .src   (dc_q),
        .sel   (pick_c),
        .bit_o (dsel_c)
    );

    obmux_pick #(.N(DIAG_N), .SW(PICK_W)) u_pick_v (
        .src   (dv_q),
        .sel   (pick_v),
        .bit_o (dsel_v)
    );

    obmux_route u_route (
        .cfg       (cfg),
        .phase     (clk),
        .cur       (cur_q),
        .volt      (volt_q),
        .diag_cur  (dsel_c),
        .diag_volt (dsel_v),
        .dat       (dat),
        .dat_n     (dat_n)
    );

endmodule

// File: rtl/obmux_chk.sv
module obmux_chk #(
    parameter int unsigned DIAG_N = 4,
    parameter int unsigned SEL_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_mode,
    input logic [1:0]        strap,
    input logic [SEL_W-1:0]  test_sel,
    input logic              volt_pd,
    input logic              mux_en,
    input logic              bs_cur,
    input logic              bs_volt,
    input logic [DIAG_N-1:0] diag_c,
    input logic [DIAG_N-1:0] diag_v,
    input logic              dat,
    input logic              dat_n
);

    logic [1:0] cls;
    assign cls = test_sel[SEL_W-1 -: 2];

    // R1: complement relation while interleaving
    a_r1_mux_inverse: assert property (@(negedge clk) disable iff (!rst_n)
        (soft_mode && cls == 2'b00 && mux_en && !volt_pd) |-> (dat_n == ~dat));

    // R1: high half of the interleave carries the voltage bit
    a_r1_high_volt: assert property (@(negedge clk) disable iff (!rst_n)
        (soft_mode && cls == 2'b00 && mux_en && !volt_pd && $past(rst_n))
        |-> (dat == $past(bs_volt)));

    // R2 / R11: plain routing shows the bit captured one edge earlier
    a_r2_plain_route: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_mode && cls == 2'b00 && !mux_en && !volt_pd && $past(rst_n))
        |-> (dat == $past(bs_volt) && dat_n == $past(bs_cur)));

    // R3: powered-down voltage channel
    a_r3_pd_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_mode && cls == 2'b00 && volt_pd && $past(rst_n))
        |-> (dat == $past(bs_cur) && dat_n == ~dat));

    // R4: current diagnostic index 0
    a_r4_diag_cur: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_mode && test_sel == {2'b01, {(SEL_W-2){1'b0}}} && $past(rst_n))
        |-> (dat_n == $past(diag_c[0])));

    // R5: voltage diagnostic index 0
    a_r5_diag_volt: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_mode && test_sel == {2'b10, {(SEL_W-2){1'b0}}} && $past(rst_n))
        |-> (dat == $past(diag_v[0])));

    // R7: strap tied high
    a_r7_strap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_mode && strap == 2'd3 && $past(rst_n))
        |-> (dat == $past(bs_volt) && dat_n == $past(bs_cur)));

    // R8: strap on clock or inverted clock
    a_r8_strap_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_mode && (strap == 2'd1 || strap == 2'd2)) |-> (dat_n == ~dat));

endmodule

bind obmux_top obmux_chk #(.DIAG_N(DIAG_N), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_mode (soft_mode),
    .strap     (strap),
    .test_sel  (test_sel),
    .volt_pd   (volt_pd),
    .mux_en    (mux_en),
    .bs_cur    (bs_cur),
    .bs_volt   (bs_volt),
    .diag_c    (diag_c),
    .diag_v    (diag_v),
    .dat       (dat),
    .dat_n     (dat_n)
);

// File: tb/sim_obmux_top.sv
`timescale 1ns/1ps
module sim_obmux_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_mode = 1'b1;
    logic [1:0] strap = 2'd0;
    logic [5:0] test_sel = 6'd0;
    logic       volt_pd = 1'b0;
    logic       mux_en = 1'b0;
    logic       bs_cur = 1'b0;
    logic       bs_volt = 1'b0;
    logic [3:0] diag_c = 4'd0;
    logic [3:0] diag_v = 4'd0;
    logic       dat, dat_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model of the captured bits
    bit       m_c, m_v;
    bit [3:0] m_dc, m_dv;

    always #4 clk = ~clk;

    obmux_top u0 (
        .clk(clk), .rst_n(rst_n), .soft_mode(soft_mode), .strap(strap),
        .test_sel(test_sel), .volt_pd(volt_pd), .mux_en(mux_en),
        .bs_cur(bs_cur), .bs_volt(bs_volt), .diag_c(diag_c), .diag_v(diag_v),
        .dat(dat), .dat_n(dat_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_c = 0; m_v = 0; m_dc = '0; m_dv = '0;
        end else begin
            m_c = bs_cur; m_v = bs_volt; m_dc = diag_c; m_dv = diag_v;
        end
    end

    function automatic bit [1:0] expect_out(bit high);
        bit p, s, m;
        if (!soft_mode) begin
            if (strap == 2'd3)      begin p = m_v; s = m_c; end
            else if (strap == 2'd0) begin m = high ? m_v : m_c; p = m; s = !m; end
            else                    begin p = m_c; s = !m_c; end
            return {p, s};
        end
        if (volt_pd)      begin p = m_c; s = !m_c; end
        else if (mux_en)  begin m = high ? m_v : m_c; p = m; s = !m; end
        else              begin p = m_v; s = m_c; end
        if (test_sel[5:4] == 2'b01) s = m_dc[test_sel[1:0]];
        if (test_sel[5:4] == 2'b10) p = m_dv[test_sel[3:2]];
        if (test_sel[5:4] == 2'b11) begin p = m_dv[test_sel[3:2]]; s = m_dc[test_sel[1:0]]; end
        return {p, s};
    endfunction

    function automatic string req_tag();
        if (!soft_mode) begin
            if (strap == 2'd3) return "R7 R10 R11";
            if (strap == 2'd0) return "R9 R10";
            return "R8 R10";
        end
        case (test_sel[5:4])
            2'b01: return "R4";
            2'b10: return "R5";
            2'b11: return "R6";
            default: ;
        endcase
        if (volt_pd) return "R3";
        if (mux_en)  return "R1";
        return "R2 R11";
    endfunction

    task automatic check(bit high, string tag);
        bit [1:0] exp;
        exp = expect_out(high);
        n_chk++;
        if ({dat, dat_n} !== exp) begin
            n_fail++;
            $display("FAIL %s phase=%0d actual dat/dat_n=%b%b expected=%b%b",
                     tag, high, dat, dat_n, exp[1], exp[0]);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            bs_cur  = 1'($urandom);
            bs_volt = 1'($urandom);
            diag_c  = 4'($urandom);
            diag_v  = 4'($urandom);
            #1 check(1'b1, req_tag());
            @(negedge clk);
            #3 check(1'b0, req_tag());
        end
    endtask

    task automatic soft_cfg(bit [5:0] sel, bit pd, bit mx);
        soft_mode = 1'b1; test_sel = sel; volt_pd = pd; mux_en = mx;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R12: reset state with changing inputs
        soft_cfg(6'd0, 1'b0, 1'b0);
        repeat (3) begin
            @(posedge clk); #2 bs_cur = 1'b1; bs_volt = 1'b1;
            #1 check(1'b1, "R12");
        end
        @(negedge clk); #3 check(1'b0, "R12");
        @(posedge clk); #2 rst_n = 1'b1;

        // R2, R11: plain routing
        run(40);
        // R1: interleave
        soft_cfg(6'd0, 1'b0, 1'b1); run(40);
        // R3: voltage power-down, both multiplex settings
        soft_cfg(6'd0, 1'b1, 1'b0); run(30);
        soft_cfg(6'd0, 1'b1, 1'b1); run(30);
        // R4, R5, R6: every diagnostic index, with several base routings
        for (int k = 0; k < 4; k++) begin
            soft_cfg({2'b01, 2'(3 - k), 2'(k)}, 1'b0, k[0]); run(20);
            soft_cfg({2'b10, 2'(k), 2'(3 - k)}, k[1], 1'b1); run(20);
            soft_cfg({2'b11, 2'(k), 2'(k + 1)}, 1'b0, 1'b0); run(20);
        end
        // R7..R10: strap control, software settings varied and ignored
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                soft_mode = 1'b0;
                strap     = 2'(s);
                test_sel  = 6'($urandom);
                volt_pd   = 1'($urandom);
                mux_en    = 1'($urandom);
                run(15);
            end
        end
        // R11: back to plain software routing after strap control
        soft_cfg(6'd0, 1'b0, 1'b0); run(20);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule